// File: doc/BRIEF.md
# RS-485 Echo-Timed Driver Enable Controller

This block drives the transmit-enable and receive-enable lines of a half-duplex RS-485 transceiver that sits beside a UART. The receiver is never switched off, so every byte the node puts on the bus comes back to its own receiver. The controller uses that returning copy as its timing reference. The driver is switched on as soon as a byte is handed to the transmitter. It is switched off on the receive-complete strobe of the echo of the final byte. That strobe fires only after the stop bit has been sampled, so the driver never lets go of the line while the last bit is still on it.

The controller keeps a count of bytes that have been sent but not yet echoed. This lets a message of several back-to-back bytes keep the driver on until the final echo. If the echo never arrives, for example because the bus is damaged, a watchdog counts baud ticks and forces the driver off. The same event raises a sticky error flag. Receive strobes that arrive while the driver is off are ordinary incoming data. They are passed on and do not touch driver control.

Top module: `rs485_echo_de`

## Requirements
- R1: The receiver-enable output `re_n` is 0 (receiver on) in every cycle, before, during and after a transmission.
- R2: After reset, `de` is 0 and `timeout_err` is 0.
- R3: A `tx_start` pulse makes `de` 1 from the next clock cycle onward.
- R4: The controller counts bytes started by `tx_start` and not yet echoed by `rx_done`. `de` stays 1 through the echoes of bytes not flagged with `tx_last`. `de` becomes 0 in the cycle after the echo that brings the count to zero, once a byte flagged with `tx_last` has been started.
- R5: When `rx_done` is 1 while `de` is 0, `rx_pass` is 1 in the same cycle and `de` does not change. When `de` is 1, `rx_pass` is 0.
- R6: While `de` is 1, `TIMEOUT_TICKS` `baud_tick` pulses (default 64, more than four 10-bit characters) with no `tx_start` and no echo in between make `de` 0 in the cycle after the last of those ticks.
- R7: The watchdog tick count restarts on every `tx_start` and on every echo.
- R8: A timeout sets `timeout_err`, which stays 1 until an `err_clear` pulse clears it. If a timeout and `err_clear` fall in the same cycle, the flag is set.
- R9: `baud_tick` pulses while `de` is 0 have no effect on `de` or `timeout_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_start | input | 1 | Strobe: a byte was handed to the UART transmitter |
| tx_last | input | 1 | Qualifies `tx_start`: this byte ends the message |
| rx_done | input | 1 | Strobe: the UART receiver finished a byte, stop bit included |
| baud_tick | input | 1 | One pulse per bit period |
| err_clear | input | 1 | Clears the timeout error flag |
| de | output | 1 | Transceiver driver enable |
| re_n | output | 1 | Transceiver receiver enable, active low |
| rx_pass | output | 1 | `rx_done` passed on as received data, when not transmitting |
| timeout_err | output | 1 | Sticky watchdog timeout flag |

## Verification
The bench runs single-byte messages and three-byte back-to-back messages. It also covers echoes that arrive before the next byte starts, and a message whose echoes never come back.

A wrong outstanding-byte count shows up at the ports one cycle after the final echo. The driver then either stays on until the watchdog fires or drops after an earlier echo.

A watchdog that is off by one, or that does not restart on an echo, shows up at `de` and `timeout_err` one cycle after the tick concerned. The bench checks exactly one tick before and one tick at the limit.

// File: rtl/rs485_echo_de.sv
module rs485_echo_de #(
  parameter int TIMEOUT_TICKS = 64,
  parameter int PEND_W        = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_start,
  input  logic tx_last,
  input  logic rx_done,
  input  logic baud_tick,
  input  logic err_clear,
  output logic de,
  output logic re_n,
  output logic rx_pass,
  output logic timeout_err
);

  localparam int TW = $clog2(TIMEOUT_TICKS + 1);

  logic [PEND_W-1:0] pend;
  logic [TW-1:0]     tcnt;
  logic              last_seen;

  logic echo, release_now, expire;

  assign re_n    = 1'b0;
  assign echo    = rx_done & de;
  assign rx_pass = rx_done & ~de;

  assign release_now = echo & ~tx_start & last_seen & (pend == PEND_W'(1));
  assign expire      = de & baud_tick & ~tx_start & ~echo &
                       (tcnt == TW'(TIMEOUT_TICKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      de          <= 1'b0;
      pend        <= '0;
      last_seen   <= 1'b0;
      tcnt        <= '0;
      timeout_err <= 1'b0;
    end else begin
      if (expire || release_now) begin
        de        <= 1'b0;
        pend      <= '0;
        last_seen <= 1'b0;
        tcnt      <= '0;
      end else begin
        if (tx_start) begin
          de        <= 1'b1;
          last_seen <= last_seen | tx_last;
        end
        if (tx_start && !(echo && pend != '0))
          pend <= pend + PEND_W'(1);
        else if (!tx_start && echo && pend != '0)
          pend <= pend - PEND_W'(1);
        if (tx_start || echo)
          tcnt <= '0;
        else if (de && baud_tick)
          tcnt <= tcnt + TW'(1);
      end
      if (expire)
        timeout_err <= 1'b1;
      else if (err_clear)
        timeout_err <= 1'b0;
    end
  end

endmodule

// File: rtl/rs485_echo_de_checker.sv
module rs485_echo_de_checker (
  input logic clk,
  input logic rst_n,
  input logic tx_start,
  input logic rx_done,
  input logic baud_tick,
  input logic err_clear,
  input logic de,
  input logic rx_pass,
  input logic timeout_err
);

  assert_de_on_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> de);

  assert_de_drop_needs_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (de && !rx_done && !baud_tick) |=> de);

  assert_pass_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !de) |-> rx_pass);

  assert_no_pass_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> !rx_pass);

  assert_err_with_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!timeout_err ##1 timeout_err) |-> $fell(de));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_err && !err_clear) |=> timeout_err);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!de && !tx_start) |=> !de);

endmodule

bind rs485_echo_de rs485_echo_de_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .rx_done(rx_done),
  .baud_tick(baud_tick), .err_clear(err_clear), .de(de),
  .rx_pass(rx_pass), .timeout_err(timeout_err)
);

// File: tb/rs485_echo_de_bench.sv
module rs485_echo_de_bench;
  localparam int TMO = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_start = 1'b0, tx_last = 1'b0, rx_done = 1'b0;
  logic baud_tick = 1'b0, err_clear = 1'b0;
  logic de, re_n, rx_pass, timeout_err;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rs485_echo_de #(.TIMEOUT_TICKS(TMO)) u_rs485_echo_de (
    .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_last(tx_last),
    .rx_done(rx_done), .baud_tick(baud_tick), .err_clear(err_clear),
    .de(de), .re_n(re_n), .rx_pass(rx_pass), .timeout_err(timeout_err)
  );

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(logic ts, logic tl, logic rd, logic bt, logic ec);
    @(negedge clk);
    tx_start = ts; tx_last = tl; rx_done = rd; baud_tick = bt; err_clear = ec;
    @(posedge clk);
    #1;
    tx_start = 0; tx_last = 0; rx_done = 0; baud_tick = 0; err_clear = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 1, 0);
  endtask

  task automatic t_reset;
    chk("R2 de after reset", de, 1'b0);
    chk("R2 err after reset", timeout_err, 1'b0);
    chk("R1 re_n after reset", re_n, 1'b0);
  endtask

  task automatic t_single;
    step(1, 1, 0, 0, 0);
    chk("R3 de on start", de, 1'b1);
    chk("R1 re_n while driving", re_n, 1'b0);
    ticks(10);
    chk("R4 de held before echo", de, 1'b1);
    @(negedge clk); rx_done = 1;
    #1 chk("R5 no pass of echo", rx_pass, 1'b0);
    @(posedge clk); #1 rx_done = 0;
    chk("R4 de off after last echo", de, 1'b0);
    chk("R8 no err on clean end", timeout_err, 1'b0);
  endtask

  task automatic t_burst;
    step(1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    chk("R4 de after 1st echo", de, 1'b1);
    step(0, 0, 1, 0, 0);
    chk("R4 de after 2nd echo", de, 1'b1);
    step(0, 0, 1, 0, 0);
    chk("R4 de off after 3rd echo", de, 1'b0);
  endtask

  task automatic t_interleave;
    step(1, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    chk("R4 de held with no last yet", de, 1'b1);
    step(1, 1, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    chk("R4 de off after final echo", de, 1'b0);
  endtask

  task automatic t_idle_rx;
    @(negedge clk); rx_done = 1;
    #1 chk("R5 pass when idle", rx_pass, 1'b1);
    @(posedge clk); #1 rx_done = 0;
    chk("R5 de untouched", de, 1'b0);
    ticks(TMO + 5);
    chk("R9 de idle ticks", de, 1'b0);
    chk("R9 err idle ticks", timeout_err, 1'b0);
  endtask

  task automatic t_timeout;
    step(1, 1, 0, 0, 0);
    ticks(TMO - 1);
    chk("R6 de one tick before limit", de, 1'b1);
    ticks(1);
    chk("R6 de off at limit", de, 1'b0);
    chk("R8 err set", timeout_err, 1'b1);
    chk("R1 re_n after timeout", re_n, 1'b0);
    ticks(3);
    chk("R8 err sticky", timeout_err, 1'b1);
    step(0, 0, 0, 0, 1);
    chk("R8 err cleared", timeout_err, 1'b0);
  endtask

  task automatic t_restart;
    step(1, 0, 0, 0, 0);
    ticks(40);
    step(0, 0, 1, 0, 0);
    ticks(TMO - 1);
    chk("R7 restart on echo", de, 1'b1);
    step(1, 1, 0, 0, 0);
    ticks(TMO - 1);
    chk("R7 restart on start", de, 1'b1);
    step(0, 0, 1, 0, 0);
    chk("R7 de off on echo", de, 1'b0);
    chk("R7 no err", timeout_err, 1'b0);
  endtask

  task automatic t_set_wins;
    step(1, 1, 0, 0, 0);
    ticks(TMO - 1);
    step(0, 0, 0, 1, 1);
    chk("R8 set wins over clear", timeout_err, 1'b1);
    step(0, 0, 0, 0, 1);
    chk("R8 cleared afterwards", timeout_err, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset;
    t_single;
    t_burst;
    t_interleave;
    t_idle_rx;
    t_timeout;
    t_restart;
    t_set_wins;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=finished");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule